// File: doc/BRIEF.md
# Multi-Lane Serial Peripheral Transfer Controller

This block is a serial peripheral interface master with `LANES` one-bit data lanes. All lanes share one chip select and one serial clock. Each lane carries its own whole word, and the words on all lanes move at the same time. The block does not spread the bits of one word across lanes. Words to send arrive on a valid/ready transmit stream. Words that are read leave on a valid/ready receive stream. A start pulse sets up each transfer and carries its length in stream words, a read/write flag and a lane mode:

- **single** (code 0, the default behaviour): uses one lane, like an ordinary one-wire master.
- **mirror** (code 1): copies one word onto every lane. It is for writes only.
- **stripe** (code 2): gives every lane a different word, dealt out round-robin from the stream.

Back-pressure rules:

- **Transmit side:** `tx_ready` is high only while the controller gathers the words for the next lane group. A word moves on a rising clock edge with `tx_valid` and `tx_ready` both high.
- **Receive side:** `rx_valid` is high only while the words of a finished group are being handed out. `rx_data` holds steady until `rx_ready` takes it.

In either waiting state the serial clock is parked low and chip select stays low. A slow producer or consumer therefore stretches the gap between word groups without breaking the transfer. A fixed parameter, `LANE_MAP`, routes each logical lane to a physical pin pair. With it, a device wired only to a higher pin can still be driven as logical lane 0.

Top module: `mlspi_ctrl`

## Requirements
- R1: Single mode (mode code 0) moves stream words one per group through logical lane 0 only. Every other lane drives 0 and its input is ignored.
- R2: Mirror mode (mode code 1) sends each transmit word on every lane at once.
- R3: In stripe mode (mode code 2), stream word k uses logical lane k mod LANES in group k div LANES. For a read, the receive stream returns each group's words in logical lane order. With 8-bit words, a read where logical lane 0 receives 0x11 and lane 1 receives 0x88 yields 0x11 then 0x88.
- R4: A request is rejected when any one of these holds:
  - mode code 3;
  - a mirror read;
  - a length of zero;
  - a stripe length that is not a multiple of LANES.
  A rejected request gives an `err` pulse of exactly one cycle in the cycle after `start`, with no chip select and no serial clock.
- R5: Timing follows clock mode 0:
  - `sclk` idles low, and each half period lasts `HALF_DIV` system cycles;
  - words are shifted most significant bit first;
  - outputs change on the falling edge, and inputs are sampled on the rising edge;
  - a transfer of G groups gives exactly G*WORD_W rising edges inside one chip-select low window.
- R6: Logical lane l drives and samples the physical pin given by bits [4l+3:4l] of `LANE_MAP`.
- R7: `tx_ready` is high only while a group is being gathered, and `sclk` stays low during that time.
- R8: `rx_valid`, once high, stays high with stable `rx_data` until accepted, and `sclk` stays low meanwhile.
- R9: `done` pulses for one cycle as chip select returns high at the end of an accepted transfer.
- R10: After reset, these are all inactive: `cs_n` high, `sclk` low, `sdo` zero, and `busy`, `done`, `err`, `tx_ready` and `rx_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| mode | input | 2 | Lane mode: 0 single, 1 mirror, 2 stripe, 3 unsupported |
| rd | input | 1 | 1 = read (fills receive stream), 0 = write (drains transmit stream) |
| nwords | input | LEN_W | Transfer length in stream words |
| busy | output | 1 | High from an accepted start until the end of the transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle rejection pulse |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Controller gathering transmit words |
| tx_data | input | WORD_W | Transmit word |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | WORD_W | Received word |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Shared chip select, active low |
| sdo | output | LANES | Serial data out, one per physical pin |
| sdi | input | LANES | Serial data in, one per physical pin |

## Verification
The assertions assume that `start` arrives only while `busy` is low. They also assume the consumer takes every word the controller offers within a bounded time. The bench keeps to this by issuing each request only after the previous `done` or `err`, and by driving `rx_ready` with finite gaps. The peripheral model in the bench changes its data only after a falling serial clock edge. Sweeps across full stripe and single lengths use patterns computed from the word index, and gapped producers and consumers exercise the parking of the clock.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

  typedef enum logic [1:0] {
    XFER_SINGLE = 2'd0,
    XFER_MIRROR = 2'd1,
    XFER_STRIPE = 2'd2
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SHIFT,
    ST_DRAIN,
    ST_CLOSE
  } ctl_state_e;

endpackage

// File: rtl/mlspi_clkdiv.sv
module mlspi_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/mlspi_lane.sv
module mlspi_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              drive_en,
  input  logic              sdi_bit,
  output logic              sdo_bit,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] txsr_q, rxsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr_q <= '0;
      rxsr_q <= '0;
    end else begin
      if (load)          txsr_q <= load_word;
      else if (shift_en) txsr_q <= {txsr_q[WORD_W-2:0], 1'b0};
      if (sample_en)     rxsr_q <= {rxsr_q[WORD_W-2:0], sdi_bit};
    end
  end

  assign sdo_bit = drive_en & txsr_q[WORD_W-1];
  assign rx_word = rxsr_q;
endmodule

// File: rtl/mlspi_route.sv
module mlspi_route #(
  parameter int          LANES    = 2,
  parameter logic [63:0] LANE_MAP = 64'hFEDC_BA98_7654_3210
) (
  input  logic [LANES-1:0] sdo_log,
  output logic [LANES-1:0] sdo_pin,
  input  logic [LANES-1:0] sdi_pin,
  output logic [LANES-1:0] sdi_log
);
  for (genvar l = 0; l < LANES; l++) begin : g_in
    localparam int PIN = int'(LANE_MAP[4*l +: 4]);
    assign sdi_log[l] = sdi_pin[PIN];
  end

  always_comb begin
    sdo_pin = '0;
    for (int p = 0; p < LANES; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (int'(LANE_MAP[4*l +: 4]) == p) sdo_pin[p] = sdo_log[l];
      end
    end
  end
endmodule

// File: rtl/mlspi_ctrl.sv
module mlspi_ctrl
  import mlspi_pkg::*;
#(
  parameter int          LANES    = 2,
  parameter int          WORD_W   = 8,
  parameter int          HALF_DIV = 2,
  parameter int          LEN_W    = 8,
  parameter logic [63:0] LANE_MAP = 64'hFEDC_BA98_7654_3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              rd,
  input  logic [LEN_W-1:0]  nwords,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              cs_n,
  output logic [LANES-1:0]  sdo,
  input  logic [LANES-1:0]  sdi
);
  localparam int                LIDX_W     = $clog2(LANES);
  localparam int                BIT_W      = $clog2(WORD_W);
  localparam logic [LIDX_W-1:0] LAST_LANE  = LIDX_W'(LANES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(WORD_W - 1);
  localparam logic [LEN_W-1:0]  STRIPE_LEN = LEN_W'(LANES);

  ctl_state_e        state_q;
  xfer_mode_e        mode_q;
  logic              rd_q;
  logic [LEN_W-1:0]  left_q;
  logic [LIDX_W-1:0] widx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              sclk_q, cs_n_q, done_q, err_q;

  logic              stripe_q, grp_last, tick, rise_ev, fall_ev;
  logic              tx_fire, rx_fire, req_bad, shifting;
  logic [LEN_W-1:0]  grp_len;
  logic [LANES-1:0]  sdo_log, sdi_log;
  logic [WORD_W-1:0] rx_word [LANES];

  // request screening
  always_comb begin
    req_bad = (nwords == '0);
    case (mode)
      2'd0:    ;
      2'd1:    if (rd) req_bad = 1'b1;
      2'd2:    if ((32'(nwords) % LANES) != 0) req_bad = 1'b1;
      default: req_bad = 1'b1;
    endcase
  end

  assign stripe_q = (mode_q == XFER_STRIPE);
  assign grp_len  = stripe_q ? STRIPE_LEN : LEN_W'(1);
  assign grp_last = !stripe_q || (widx_q == LAST_LANE);
  assign shifting = (state_q == ST_SHIFT);
  assign rise_ev  = tick && !sclk_q;
  assign fall_ev  = tick && sclk_q;
  assign tx_ready = (state_q == ST_FILL);
  assign rx_valid = (state_q == ST_DRAIN);
  assign tx_fire  = tx_ready && tx_valid;
  assign rx_fire  = rx_valid && rx_ready;

  mlspi_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (shifting),
    .tick (tick)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic active, take;
    assign active = (mode_q != XFER_SINGLE) || (l == 0);
    assign take   = tx_fire && ((mode_q == XFER_MIRROR) ||
                    (stripe_q ? (widx_q == LIDX_W'(l)) : (l == 0)));
    mlspi_lane #(.WORD_W(WORD_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_word(tx_data),
      .shift_en (shifting && fall_ev && (bit_q != LAST_BIT)),
      .sample_en(shifting && rise_ev),
      .drive_en ((state_q != ST_IDLE) && !rd_q && active),
      .sdi_bit  (sdi_log[l]),
      .sdo_bit  (sdo_log[l]),
      .rx_word  (rx_word[l])
    );
  end

  mlspi_route #(.LANES(LANES), .LANE_MAP(LANE_MAP)) u_route (
    .sdo_log(sdo_log),
    .sdo_pin(sdo),
    .sdi_pin(sdi),
    .sdi_log(sdi_log)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= XFER_SINGLE;
      rd_q    <= 1'b0;
      left_q  <= '0;
      widx_q  <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              mode_q  <= xfer_mode_e'(mode);
              rd_q    <= rd;
              left_q  <= nwords;
              widx_q  <= '0;
              bit_q   <= '0;
              cs_n_q  <= 1'b0;
              state_q <= rd ? ST_SHIFT : ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (tx_fire) begin
            if (grp_last) begin
              widx_q  <= '0;
              bit_q   <= '0;
              state_q <= ST_SHIFT;
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
          end else if (fall_ev) begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              left_q <= left_q - grp_len;
              bit_q  <= '0;
              widx_q <= '0;
              if (rd_q)                  state_q <= ST_DRAIN;
              else if (left_q == grp_len) state_q <= ST_CLOSE;
              else                       state_q <= ST_FILL;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (rx_fire) begin
            if (grp_last) begin
              widx_q  <= '0;
              state_q <= (left_q == '0) ? ST_CLOSE : ST_SHIFT;
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        ST_CLOSE: begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_data = rx_word[widx_q];
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
endmodule

// File: rtl/mlspi_ctrl_chk.sv
module mlspi_ctrl_chk #(
  parameter int LANES  = 2,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic              cs_n,
  input logic [LANES-1:0]  sdo
);
  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy && !sclk));

  assert_sclk_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sdo == '0));

  assert_fill_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!sclk && !cs_n));

  assert_drain_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!sclk && !cs_n));

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_streams_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && rx_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
endmodule

bind mlspi_ctrl mlspi_ctrl_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/mlspi_ctrl_bench.sv
module mlspi_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int          LANES = 2;
  localparam int          WW    = 8;
  localparam int          HALF  = 2;
  localparam int          LW    = 8;
  localparam logic [63:0] MAP   = 64'hFEDC_BA98_7654_3201;
  localparam int          PIN0  = 1;  // physical pin of logical lane 0
  localparam int          PIN1  = 0;  // physical pin of logical lane 1

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [LW-1:0] nwords = '0;
  logic busy, done, err;
  logic tx_valid = 1'b0, tx_ready;
  logic [WW-1:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b0;
  logic [WW-1:0] rx_data;
  logic sclk, cs_n;
  logic [LANES-1:0] sdo, sdi;

  mlspi_ctrl #(.LANES(LANES), .WORD_W(WW), .HALF_DIV(HALF), .LEN_W(LW), .LANE_MAP(MAP))
  u_mlspi_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd(rd), .nwords(nwords),
    .busy(busy), .done(done), .err(err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .sdi(sdi)
  );

  initial forever #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [WW-1:0] slv_out [LANES][260];
  logic [WW-1:0] slv_in  [LANES][260];
  logic [WW-1:0] txw [256];
  logic [WW-1:0] rxw [256];
  logic [WW-1:0] s_osh [LANES];
  logic [WW-1:0] s_ish [LANES];
  int rise_cnt = 0, hi_cnt = 0, cs_falls = 0, park_bad = 0;
  int s_idx, s_bit;

  function automatic int pin_of(input int l);
    return (l == 0) ? PIN0 : PIN1;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // watchdog
  initial begin
    #(5ns * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // line monitors
  initial forever begin @(posedge sclk); rise_cnt++; end
  initial forever begin @(negedge cs_n); cs_falls++; end
  initial forever begin
    @(negedge clk);
    if (sclk === 1'b1) hi_cnt++;
    if ((tx_ready === 1'b1 || rx_valid === 1'b1 || cs_n === 1'b1) && sclk === 1'b1) park_bad++;
  end

  // peripheral model: mode 0, one shift pair per physical pin
  initial begin
    sdi = '0;
    forever begin
      @(negedge cs_n);
      s_idx = 0;
      s_bit = 0;
      for (int p = 0; p < LANES; p++) begin
        s_osh[p] = slv_out[p][0];
        s_ish[p] = '0;
        sdi[p]   = s_osh[p][WW-1];
      end
      while (cs_n === 1'b0) begin
        @(posedge sclk or posedge cs_n);
        if (cs_n !== 1'b0) break;
        for (int p = 0; p < LANES; p++) s_ish[p] = {s_ish[p][WW-2:0], sdo[p]};
        @(negedge sclk);
        s_bit++;
        if (s_bit == WW) begin
          for (int p = 0; p < LANES; p++) begin
            slv_in[p][s_idx] = s_ish[p];
            s_osh[p] = slv_out[p][s_idx+1];
          end
          s_idx++;
          s_bit = 0;
        end else begin
          for (int p = 0; p < LANES; p++) s_osh[p] = {s_osh[p][WW-2:0], 1'b0};
        end
        for (int p = 0; p < LANES; p++) sdi[p] = s_osh[p][WW-1];
      end
    end
  end

  task automatic clear_counts();
    rise_cnt = 0; hi_cnt = 0; cs_falls = 0; park_bad = 0;
  endtask

  task automatic request(input logic [1:0] m, input logic r, input int n);
    @(negedge clk);
    start = 1'b1; mode = m; rd = r; nwords = LW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int n, input int gap);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      tx_valid = 1'b0;
      repeat (gap) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = txw[k];
      while (tx_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic collect(input int n, input int gap);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      rx_ready = 1'b0;
      repeat (gap) @(negedge clk);
      rx_ready = 1'b1;
      while (rx_valid !== 1'b1) @(negedge clk);
      rxw[k] = rx_data;
      @(negedge clk);
    end
    rx_ready = 1'b0;
  endtask

  task automatic finish_xfer(input string req);
    while (done !== 1'b1) @(negedge clk);
    chk(req, "cs_n high with done", 32'(cs_n), 32'd1);
    @(negedge clk);
    chk("R9", "done lasts one cycle", 32'(done), 32'd0);
  endtask

  task automatic write_xfer(input logic [1:0] m, input int n, input int gap);
    clear_counts();
    request(m, 1'b0, n);
    feed(n, gap);
    finish_xfer("R9");
  endtask

  task automatic read_xfer(input logic [1:0] m, input int n, input int gap);
    clear_counts();
    request(m, 1'b1, n);
    collect(n, gap);
    finish_xfer("R9");
  endtask

  task automatic reject(input logic [1:0] m, input logic r, input int n, input string what);
    clear_counts();
    @(negedge clk);
    start = 1'b1; mode = m; rd = r; nwords = LW'(n);
    @(negedge clk);
    start = 1'b0;
    chk("R4", {what, " err raised"}, 32'(err), 32'd1);
    chk("R4", {what, " not busy"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk("R4", {what, " err one cycle"}, 32'(err), 32'd0);
    repeat (10) @(negedge clk);
    chk("R4", {what, " no chip select"}, 32'(cs_falls), 32'd0);
    chk("R4", {what, " no sclk"}, 32'(rise_cnt), 32'd0);
  endtask

  initial begin
    for (int p = 0; p < LANES; p++)
      for (int g = 0; g < 260; g++) slv_out[p][g] = '0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "cs_n", 32'(cs_n), 32'd1);
    chk("R10", "sclk", 32'(sclk), 32'd0);
    chk("R10", "sdo", 32'(sdo), 32'd0);
    chk("R10", "busy/done/err", {29'd0, busy, done, err}, 32'd0);
    chk("R10", "stream flags", {30'd0, tx_ready, rx_valid}, 32'd0);

    // R4 rejections
    reject(2'd3, 1'b0, 4, "code 3");
    reject(2'd1, 1'b1, 2, "mirror read");
    reject(2'd2, 1'b0, 3, "stripe odd length");
    reject(2'd2, 1'b1, 1, "stripe short read");
    reject(2'd0, 1'b0, 0, "zero length");

    // R1/R6/R5: single write sweep, 255 words through logical lane 0
    for (int k = 0; k < 255; k++) txw[k] = WW'(k + 1);
    write_xfer(2'd0, 255, 0);
    for (int k = 0; k < 255; k++) begin
      chk("R1", $sformatf("single word %0d on mapped pin", k), 32'(slv_in[PIN0][k]), 32'(txw[k]));
      chk("R1", $sformatf("single word %0d other pin low", k), 32'(slv_in[PIN1][k]), 32'd0);
    end
    chk("R5", "single rising edges", 32'(rise_cnt), 32'(255 * WW));
    chk("R5", "single high cycles", 32'(hi_cnt), 32'(255 * WW * HALF));
    chk("R5", "one chip select window", 32'(cs_falls), 32'd1);

    // R2: mirror write with gaps
    for (int k = 0; k < 16; k++) txw[k] = WW'(k * 17 + 3);
    write_xfer(2'd1, 16, 3);
    for (int k = 0; k < 16; k++) begin
      chk("R2", $sformatf("mirror word %0d pin0", k), 32'(slv_in[0][k]), 32'(txw[k]));
      chk("R2", $sformatf("mirror word %0d pin1", k), 32'(slv_in[1][k]), 32'(txw[k]));
    end
    chk("R7", "mirror sclk parked while waiting", 32'(park_bad), 32'd0);

    // R3/R6: stripe write sweep
    for (int k = 0; k < 254; k++) txw[k] = WW'((k * 37 + 5) & 8'hFF);
    write_xfer(2'd2, 254, 0);
    for (int k = 0; k < 254; k++)
      chk("R3", $sformatf("stripe write word %0d", k),
          32'(slv_in[pin_of(k % 2)][k / 2]), 32'(txw[k]));
    chk("R5", "stripe rising edges", 32'(rise_cnt), 32'(127 * WW));

    // R7: starved producer
    for (int k = 0; k < 6; k++) txw[k] = WW'(8'hA0 + k);
    write_xfer(2'd2, 6, 5);
    for (int k = 0; k < 6; k++)
      chk("R7", $sformatf("starved stripe word %0d", k),
          32'(slv_in[pin_of(k % 2)][k / 2]), 32'(txw[k]));
    chk("R7", "sclk parked while tx starved", 32'(park_bad), 32'd0);
    chk("R7", "starved rising edges", 32'(rise_cnt), 32'(3 * WW));

    // R3: stripe read sweep, group 0 carries 0x11 / 0x88
    for (int g = 0; g < 127; g++) begin
      slv_out[PIN0][g] = (g == 0) ? 8'h11 : WW'((g * 7 + 1) & 8'hFF);
      slv_out[PIN1][g] = (g == 0) ? 8'h88 : WW'((g * 13 + 200) & 8'hFF);
    end
    read_xfer(2'd2, 254, 0);
    chk("R3", "first read word", 32'(rxw[0]), 32'h11);
    chk("R3", "second read word", 32'(rxw[1]), 32'h88);
    for (int k = 0; k < 254; k++)
      chk("R3", $sformatf("stripe read word %0d", k),
          32'(rxw[k]), 32'(slv_out[pin_of(k % 2)][k / 2]));
    chk("R1", "read drives no data", 32'(slv_in[0][5] | slv_in[1][5]), 32'd0);

    // R8: slow consumer
    read_xfer(2'd2, 8, 4);
    for (int k = 0; k < 8; k++)
      chk("R8", $sformatf("slow consumer word %0d", k),
          32'(rxw[k]), 32'(slv_out[pin_of(k % 2)][k / 2]));
    chk("R8", "sclk parked while rx waits", 32'(park_bad), 32'd0);

    // R1/R6: single read, other pin carries different data
    for (int g = 0; g < 10; g++) begin
      slv_out[PIN0][g] = WW'((g * 29 + 3) & 8'hFF);
      slv_out[PIN1][g] = ~WW'((g * 29 + 3) & 8'hFF);
    end
    read_xfer(2'd0, 10, 1);
    for (int k = 0; k < 10; k++)
      chk("R6", $sformatf("single read word %0d from mapped pin", k),
          32'(rxw[k]), 32'(slv_out[PIN0][k]));
    chk("R5", "single read rising edges", 32'(rise_cnt), 32'(10 * WW));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule